// File: doc/BRIEF.md
# Two-Requester Priority Arbiter with Idle Parking

This block arbitrates between two requesters that share one resource. One requester has high priority and one has low priority. Both request lines are sampled on each rising clock edge. The decision is held in flops, so it shows on the grant outputs during the cycle after the edge.

When the high-priority side is granted, it keeps the grant for a minimum window of `HOLD` cycles. A new high-priority request during that window starts the window again. The low-priority side is granted only when no window is running and the high-priority line is low.

The grant never goes idle. When nobody asks, it rests on the low-priority side, so that side can use the resource at once. After reset, exactly one grant is high in every cycle.

Top module: `prio_park_arb`

## Requirements
- R1: Grant outputs are registered. The grants seen in a cycle depend only on the state and inputs sampled at the preceding rising clock edge.
- R2: If `req_hi` is sampled high, `gnt_hi` is high and `gnt_lo` is low in the next cycle, whatever the value of `req_lo`.
- R3: After `req_hi` is sampled high, `gnt_hi` stays high for at least `HOLD` consecutive cycles (default 2), even if both requests drop.
- R4: A `req_hi` sample taken while a window is running restarts the window at full length. A `req_hi` held high therefore keeps `gnt_hi` high for as long as it is held.
- R5: If `req_lo` is sampled high, `req_hi` is sampled low and no window is running, `gnt_lo` is high in the next cycle.
- R6: If both requests are sampled low and no window is running, `gnt_lo` is high in the next cycle (the grant is parked on the low-priority side).
- R7: A `req_lo` sampled while a window is running is not granted. `gnt_hi` stays high until the window ends.
- R8: `gnt_hi` and `gnt_lo` are never high in the same cycle.
- R9: A rising edge with `rst` high (synchronous, active high) clears both grants and cancels any running window.
- R10: From the first rising edge at which `rst` is low, exactly one of `gnt_hi` and `gnt_lo` is high in every cycle until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| req_hi | input | 1 | High-priority request |
| req_lo | input | 1 | Low-priority request |
| gnt_hi | output | 1 | Grant to the high-priority requester (registered) |
| gnt_lo | output | 1 | Grant to the low-priority requester (registered, also the idle parking position) |

## Verification
The bench builds two copies side by side from the same stimulus: one with `HOLD` = 2 and one with `HOLD` = 4. The copy with `HOLD` = 4 uses a three-bit counter. This exercises counter widths other than the default and opens gaps where a low-priority request lands deep inside a window. A second high-priority request can then restart the window before the first one has run out. Random request patterns with a fixed seed, together with a reset in mid-run, reach restarts at every remaining count. They also reach the exact cycle where a window ends.

// File: rtl/prio_park_arb.sv
module prio_park_arb #(
  parameter int HOLD = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req_hi,
  input  logic req_lo,
  output logic gnt_hi,
  output logic gnt_lo
);
  localparam int CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] RELOAD = CW'(HOLD - 1);

  logic [CW-1:0] left_q;
  logic          win_on;

  assign win_on = (left_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_hi <= 1'b0;
      gnt_lo <= 1'b0;
      left_q <= '0;
    end else if (req_hi) begin
      gnt_hi <= 1'b1;
      gnt_lo <= 1'b0;
      left_q <= RELOAD;
    end else if (win_on) begin
      gnt_hi <= 1'b1;
      gnt_lo <= 1'b0;
      left_q <= left_q - 1'b1;
    end else begin
      gnt_hi <= 1'b0;
      gnt_lo <= 1'b1;
    end
  end

  logic unused_lo;
  assign unused_lo = req_lo;
endmodule

// File: rtl/prio_park_arb_chk.sv
module prio_park_arb_chk #(
  parameter int HOLD = 2
) (
  input logic clk,
  input logic rst,
  input logic req_hi,
  input logic req_lo,
  input logic gnt_hi,
  input logic gnt_lo
);
  localparam int CW = $clog2(HOLD + 1);

  logic [CW-1:0] pend;
  logic          armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend  <= '0;
      armed <= 1'b0;
    end else begin
      armed <= 1'b1;
      if (req_hi) pend <= CW'(HOLD - 1);
      else if (pend != '0) pend <= pend - 1'b1;
    end
  end

  AST_HI_WINS:  assert property (@(posedge clk) disable iff (rst) req_hi |=> (gnt_hi && !gnt_lo)); // R2
  AST_WINDOW:   assert property (@(posedge clk) disable iff (rst) (pend != '0) |=> gnt_hi); // R3
  AST_LO_ALONE: assert property (@(posedge clk) disable iff (rst) (!req_hi && req_lo && pend == '0) |=> gnt_lo); // R5
  AST_PARKED:   assert property (@(posedge clk) disable iff (rst) (!req_hi && !req_lo && pend == '0) |=> gnt_lo); // R6
  AST_NO_BOTH:  assert property (@(posedge clk) !(gnt_hi && gnt_lo)); // R8
  AST_RST_CLR:  assert property (@(posedge clk) rst |=> (!gnt_hi && !gnt_lo)); // R9
  AST_ONE_HOT:  assert property (@(posedge clk) disable iff (rst) armed |-> ($countones({gnt_hi, gnt_lo}) == 1)); // R10
endmodule

bind prio_park_arb prio_park_arb_chk #(.HOLD(HOLD)) u_chk (
  .clk(clk), .rst(rst), .req_hi(req_hi), .req_lo(req_lo),
  .gnt_hi(gnt_hi), .gnt_lo(gnt_lo)
);

// File: tb/prio_park_arb_bench.sv
module prio_park_arb_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1, req_hi = 1'b0, req_lo = 1'b0;
  logic gh_a, gl_a, gh_b, gl_b;
  int total = 0, bad = 0;
  int hold_a = 0, hold_b = 0;
  logic eh_a = 1'b0, el_a = 1'b0, eh_b = 1'b0, el_b = 1'b0;
  logic live = 1'b0;
  bit done = 1'b0;

  prio_park_arb #(.HOLD(2)) u_prio_park_arb (
    .clk(clk), .rst(rst), .req_hi(req_hi), .req_lo(req_lo), .gnt_hi(gh_a), .gnt_lo(gl_a));
  prio_park_arb #(.HOLD(4)) u_prio_park_arb_h4 (
    .clk(clk), .rst(rst), .req_hi(req_hi), .req_lo(req_lo), .gnt_hi(gh_b), .gnt_lo(gl_b));

  function automatic string tag_of(logic r, logic h, logic l, int hold);
    if (r) return "R9";
    if (h && l) return "R2";
    if (h && hold > 0) return "R4";
    if (h) return "R1";
    if (hold > 0) return l ? "R7" : "R3";
    return l ? "R5" : "R6";
  endfunction

  task automatic model(input int len, input logic r, h, inout int hold, output logic eh, el);
    if (r) begin eh = 0; el = 0; hold = 0; end
    else if (h) begin eh = 1; el = 0; hold = len - 1; end
    else if (hold > 0) begin eh = 1; el = 0; hold = hold - 1; end
    else begin eh = 0; el = 1; end
  endtask

  task automatic check(string req, string who, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, who, act, exp, $time);
    end
  endtask

  task automatic step(input logic r, h, l);
    string ta, tb;
    @(negedge clk);
    rst = r; req_hi = h; req_lo = l;
    @(posedge clk);
    ta = tag_of(r, h, l, hold_a);
    tb = tag_of(r, h, l, hold_b);
    model(2, r, h, hold_a, eh_a, el_a);
    model(4, r, h, hold_b, eh_b, el_b);
    #1;
    check(ta, "hold2 gnt_hi", gh_a, eh_a);
    check(ta, "hold2 gnt_lo", gl_a, el_a);
    check(tb, "hold4 gnt_hi", gh_b, eh_b);
    check(tb, "hold4 gnt_lo", gl_b, el_b);
    check("R8", "hold2 exclusive", gh_a & gl_a, 1'b0);
    check("R8", "hold4 exclusive", gh_b & gl_b, 1'b0);
    live = !r;
    if (live) begin
      check("R10", "hold2 one-hot", gh_a ^ gl_a, 1'b1);
      check("R10", "hold4 one-hot", gh_b ^ gl_b, 1'b1);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) step(1, 0, 0);
    step(0, 0, 0); step(0, 0, 0);
    step(0, 0, 1); step(0, 0, 1);
    step(0, 1, 0);
    repeat (5) step(0, 0, 0);
    step(0, 1, 1);
    repeat (4) step(0, 0, 1);
    repeat (6) step(0, 1, 0);
    repeat (5) step(0, 0, 0);
    step(0, 1, 0); step(0, 0, 0); step(0, 1, 0);
    repeat (6) step(0, 0, 1);
    step(0, 1, 0); step(1, 0, 0);
    step(0, 0, 0); step(0, 0, 1);
    for (int i = 0; i < 4000; i++) begin
      logic h, l, r;
      h = ($urandom % 4) == 0;
      l = ($urandom % 2) == 0;
      r = ($urandom % 300) == 0;
      step(r, h, l);
    end
    step(0, 0, 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule